// File: doc/BRIEF.md
# Block Check Code Unit for a Half-Duplex Block Protocol

This unit sits next to a character-level serial engine that talks to a smart card using the block-oriented T=1 protocol. It keeps one running check code for the transmit direction and one for the receive direction.

On transmit, firmware marks the start of a block and then streams the block bytes through the unit towards the serial engine. It then marks the end of the block. The unit appends the check bytes to the outgoing stream itself. On receive, the unit folds every byte it sees, including the trailing check bytes, into its own code. When the end of the block is marked, it reports whether the result equals the residue of an error-free block.

Two codes are offered, and firmware picks one. The longitudinal code is a one-byte XOR. The cyclic code is a 16-bit CRC sent as two bytes. A master enable turns the whole check function off. The transmit path then becomes a plain pass-through. The outgoing stream uses valid/ready: a byte moves only on a cycle where both are high. While `m_valid` is high and `m_ready` is low, `m_data` is held. `s_ready` is low while the output register is occupied and not being drained, and during check-byte insertion. The receive input never stalls: `rx_ready` is tied high, so every cycle with `rx_valid` high delivers a byte.

Top module: `t1chk_unit`

## Requirements
- R1: After reset, `m_valid`, `tx_busy`, `rx_done` and `err_flag` are 0, and `s_ready` is 1.
- R2: Every byte accepted on the input stream appears exactly once, in order, on the output stream. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change.
- R3: With `cfg_crc`=0 and `cfg_en`=1, a `tx_end` strobe appends one byte equal to the XOR of all bytes accepted since `tx_start`. An empty block appends 0x00.
- R4: With `cfg_crc`=1 and `cfg_en`=1, a `tx_end` strobe appends two bytes, high byte first. The code is a CRC with polynomial 0x1021, processed most significant bit first, starting from 0xFFFF, with no final inversion. An empty block therefore appends 0xFF 0xFF, and the ASCII string "123456789" appends 0x29 0xB1.
- R5: From the cycle after `tx_end` until the last check byte has been loaded into the output register, `tx_busy` is 1 and `s_ready` is 0. `tx_start` resets the code to the start value of the selected mode.
- R6: Each `rx_end` strobe with `cfg_en`=1 produces a one-cycle `rx_done` pulse on the following cycle. `rx_ok` is 1 exactly when the code over all bytes since `rx_start`, including the received check bytes, is zero. Zero is the residue of a correct block in both modes. A byte that arrives in the same cycle as `rx_end` is included.
- R7: A failed receive check sets `err_flag` in the same cycle as `rx_done`. The flag stays set through later passing blocks until `err_clr` is pulsed. If a failure and `err_clr` land in the same cycle, the flag ends up set.
- R8: With `cfg_en`=0, bytes still pass through as in R2. A `tx_end` strobe appends nothing and leaves `tx_busy` at 0. An `rx_end` strobe produces no `rx_done` and leaves `err_flag` unchanged.
- R9: If `tx_end` is high in the same cycle that the last block byte is accepted, that byte is included in the appended code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Master enable of check generation and checking |
| cfg_crc | input | 1 | 1 selects the 16-bit cyclic code, 0 selects the XOR code |
| tx_start | input | 1 | Strobe: start of an outgoing block, resets the transmit code |
| tx_end | input | 1 | Strobe: end of an outgoing block, starts check-byte insertion |
| s_valid | input | 1 | Outgoing block byte is valid |
| s_ready | output | 1 | Unit accepts the outgoing byte |
| s_data | input | 8 | Outgoing block byte |
| m_valid | output | 1 | Byte towards the serial engine is valid |
| m_ready | input | 1 | Serial engine accepts the byte |
| m_data | output | 8 | Byte towards the serial engine |
| tx_busy | output | 1 | Check bytes are being inserted |
| rx_start | input | 1 | Strobe: start of an incoming block, resets the receive code |
| rx_end | input | 1 | Strobe: end of an incoming block, triggers the comparison |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | Always 1; the receive path never stalls |
| rx_data | input | 8 | Incoming byte |
| rx_done | output | 1 | One-cycle pulse: a comparison result is available |
| rx_ok | output | 1 | Result of the latest comparison, 1 = match |
| err_flag | output | 1 | Sticky receive check failure |
| err_clr | input | 1 | Clears `err_flag` |

## Verification
A corrupted transmit code is only visible at the end of a block. It shows up as wrong check bytes on `m_data`, at the earliest two cycles after `tx_end` when `m_ready` is high. Until then the passed-through bytes look correct, so every transmit scenario compares the complete appended code against a reference computed in the bench. A corrupted receive code shows up as a wrong `rx_ok` exactly one cycle after `rx_end`. A stuck insertion state shows up at once as `s_ready` held low and `tx_busy` held high. A lost or duplicated byte in the output register shows up as a length or order mismatch of the collected stream.

// File: rtl/t1chk_pkg.sv
`timescale 1ns/1ps
package t1chk_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 16;
  localparam logic [CODE_W-1:0] CRC_POLY_DEF = 16'h1021;
  localparam logic [CODE_W-1:0] CRC_SEED_DEF = 16'hFFFF;

  typedef enum logic [0:0] {
    TX_PASS   = 1'b0,
    TX_INSERT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/t1chk_accum.sv
`timescale 1ns/1ps
module t1chk_accum #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_mode,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  code,
  output logic [CRC_W-1:0]  code_next
);
  localparam int PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] code_q;
  logic [CRC_W-1:0] base;

  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c_in,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] xor_fold(input logic [CRC_W-1:0] c_in,
                                                input logic [DATA_W-1:0] d);
    return {{PAD_W{1'b0}}, c_in[DATA_W-1:0] ^ d};
  endfunction

  always_comb begin
    if (clr) base = crc_mode ? SEED : '0;
    else     base = code_q;
    if (upd) code_next = crc_mode ? crc_fold(base, din) : xor_fold(base, din);
    else     code_next = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_next;
  end

  assign code = code_q;

  AST_CLR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> (code == ($past(crc_mode) ? SEED : '0))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(code)); // R2
endmodule

// File: rtl/t1chk_tx.sv
`timescale 1ns/1ps
module t1chk_tx
  import t1chk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              crc_mode,
  input  logic              blk_start,
  input  logic              blk_end,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  localparam int NLANES = CRC_W / DATA_W;
  localparam int IDX_W  = (NLANES > 1) ? $clog2(NLANES) : 1;
  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(NLANES - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  lane_q;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic              slot_free;
  logic              take;
  logic [CRC_W-1:0]  code;
  logic [CRC_W-1:0]  code_next;
  logic [DATA_W-1:0] lane [NLANES];
  logic [DATA_W-1:0] chk_byte;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane[g] = code[g*DATA_W +: DATA_W];
  end

  assign slot_free = !out_valid_q || out_ready;
  assign in_ready  = (state_q == TX_PASS) && slot_free;
  assign take      = in_valid && in_ready;
  assign chk_byte  = crc_mode ? lane[lane_q] : lane[0];

  t1chk_accum #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_mode  (crc_mode),
    .clr       (blk_start),
    .upd       (take),
    .din       (in_data),
    .code      (code),
    .code_next (code_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TX_PASS;
      lane_q      <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      case (state_q)
        TX_PASS: begin
          if (take) begin
            out_valid_q <= 1'b1;
            out_data_q  <= in_data;
          end else if (out_ready) begin
            out_valid_q <= 1'b0;
          end
          if (blk_end && en) begin
            state_q <= TX_INSERT;
            lane_q  <= crc_mode ? LAST_LANE : '0;
          end
        end
        default: begin
          if (slot_free) begin
            out_valid_q <= 1'b1;
            out_data_q  <= chk_byte;
            if (lane_q == '0) state_q <= TX_PASS;
            else              lane_q  <= lane_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign busy      = (state_q == TX_INSERT);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R2

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R5

  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && blk_end)); // R8

  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_start) |=> $stable(code)); // R3
endmodule

// File: rtl/t1chk_rx.sv
`timescale 1ns/1ps
module t1chk_rx #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              crc_mode,
  input  logic              blk_start,
  input  logic              blk_end,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              err_clr,
  output logic              done,
  output logic              ok,
  output logic              err
);
  logic [CRC_W-1:0] code;
  logic [CRC_W-1:0] code_next;
  logic             done_q;
  logic             ok_q;
  logic             err_q;
  logic             judge;
  logic             match;

  t1chk_accum #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_mode  (crc_mode),
    .clr       (blk_start),
    .upd       (in_valid),
    .din       (in_data),
    .code      (code),
    .code_next (code_next)
  );

  assign judge = blk_end && en;
  assign match = (code_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= judge;
      if (judge) ok_q <= match;
      if (judge && !match) err_q <= 1'b1;
      else if (err_clr)    err_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign ok   = ok_q;
  assign err  = err_q;

  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(blk_end && en)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R7

  AST_FAIL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> err); // R7
endmodule

// File: rtl/t1chk_unit.sv
`timescale 1ns/1ps
module t1chk_unit
  import t1chk_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int CRC_W  = CODE_W,
  parameter logic [CRC_W-1:0] POLY = CRC_POLY_DEF,
  parameter logic [CRC_W-1:0] SEED = CRC_SEED_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_crc,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              tx_busy,
  input  logic              rx_start,
  input  logic              rx_end,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_ok,
  output logic              err_flag,
  input  logic              err_clr
);
  t1chk_tx #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .crc_mode  (cfg_crc),
    .blk_start (tx_start),
    .blk_end   (tx_end),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (s_data),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data),
    .busy      (tx_busy)
  );

  t1chk_rx #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .crc_mode  (cfg_crc),
    .blk_start (rx_start),
    .blk_end   (rx_end),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .err_clr   (err_clr),
    .done      (rx_done),
    .ok        (rx_ok),
    .err       (err_flag)
  );

  assign rx_ready = 1'b1;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !tx_busy) |=> !tx_busy); // R8
endmodule

// File: tb/tb_t1chk_unit.sv
`timescale 1ns/1ps
module tb_t1chk_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_crc = 1'b0;
  logic tx_start = 1'b0, tx_end = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [7:0] m_data;
  logic tx_busy;
  logic rx_start = 1'b0, rx_end = 1'b0, rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] rx_data = '0;
  logic rx_done, rx_ok, err_flag;
  logic err_clr = 1'b0;

  int checks = 0;
  int fails = 0;
  int bp = 1;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] got[$];

  always #10 clk = ~clk;

  t1chk_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_crc(cfg_crc),
    .tx_start(tx_start), .tx_end(tx_end),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .tx_busy(tx_busy),
    .rx_start(rx_start), .rx_end(rx_end), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_done(rx_done), .rx_ok(rx_ok), .err_flag(err_flag),
    .err_clr(err_clr)
  );

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (bp)
      0: m_ready <= 1'b0;
      1: m_ready <= 1'b1;
      2: m_ready <= ~m_ready;
      default: m_ready <= lfsr[0];
    endcase
  end

  always @(posedge clk) if (rst_n && m_valid && m_ready) got.push_back(m_data);

  function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[k]) begin
      c = c ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_lrc(input logic [7:0] b[$]);
    logic [7:0] x = 8'h00;
    foreach (b[k]) x = x ^ b[k];
    return x;
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit with_end);
    bit r;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    forever begin
      r = s_ready;
      tx_end = with_end && r;
      @(negedge clk);
      if (r) break;
    end
    s_valid = 1'b0;
    tx_end  = 1'b0;
  endtask

  task automatic pulse_tx_start();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic pulse_tx_end();
    @(negedge clk); tx_end = 1'b1;
    @(negedge clk); tx_end = 1'b0;
  endtask

  task automatic wait_out(input int n);
    int t = 0;
    while (got.size() < n && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic tx_block(input string req, input logic [7:0] b[$], input bit crc,
                          input bit coincide);
    logic [7:0] exp[$];
    logic [15:0] c;
    got.delete();
    cfg_crc = crc;
    exp = b;
    if (crc) begin c = ref_crc(b); exp.push_back(c[15:8]); exp.push_back(c[7:0]); end
    else exp.push_back(ref_lrc(b));
    pulse_tx_start();
    foreach (b[k]) send_byte(b[k], coincide && (k == b.size() - 1));
    if (!coincide) pulse_tx_end();
    wait_out(exp.size());
    repeat (4) @(negedge clk);
    chk(got.size() == exp.size(), req, "stream length", got.size(), exp.size());
    foreach (exp[k]) if (k < got.size())
      chk(got[k] == exp[k], req, $sformatf("byte %0d", k), got[k], exp[k]);
    chk(!tx_busy && s_ready, req, "idle after block", tx_busy, 0);
  endtask

  task automatic test_reset();
    chk(!m_valid, "R1", "m_valid", m_valid, 0);
    chk(!tx_busy, "R1", "tx_busy", tx_busy, 0);
    chk(!rx_done, "R1", "rx_done", rx_done, 0);
    chk(!err_flag, "R1", "err_flag", err_flag, 0);
    chk(s_ready, "R1", "s_ready", s_ready, 1);
    chk(rx_ready, "R6", "rx_ready", rx_ready, 1);
  endtask

  task automatic test_lrc_tx();
    logic [7:0] b[$] = '{8'h01, 8'h02, 8'h04, 8'h80, 8'h33};
    bp = 2;
    tx_block("R3", b, 1'b0, 1'b0);
    bp = 1;
    b.delete();
    tx_block("R3", b, 1'b0, 1'b0);
  endtask

  task automatic test_crc_tx();
    logic [7:0] b[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(ref_crc(b) == 16'h29B1, "R4", "bench reference", ref_crc(b), 16'h29B1);
    bp = 3;
    tx_block("R4", b, 1'b1, 1'b0);
    bp = 2;
    b = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    tx_block("R2", b, 1'b1, 1'b0);
    bp = 1;
  endtask

  task automatic test_coincident_end();
    logic [7:0] b[$] = '{8'h10, 8'h20, 8'h47};
    bp = 1;
    tx_block("R9", b, 1'b1, 1'b1);
    tx_block("R9", b, 1'b0, 1'b1);
  endtask

  task automatic test_insert_stall();
    got.delete();
    cfg_crc = 1'b1;
    bp = 0;
    repeat (2) @(negedge clk);
    pulse_tx_start();
    pulse_tx_end();
    chk(tx_busy, "R5", "busy after end", tx_busy, 1);
    chk(!s_ready, "R5", "s_ready during insert", s_ready, 0);
    repeat (3) @(negedge clk);
    chk(tx_busy && !s_ready, "R5", "still stalled", tx_busy, 1);
    chk(m_valid && m_data == 8'hFF, "R5", "held first check byte", m_data, 8'hFF);
    bp = 1;
    wait_out(2);
    repeat (2) @(negedge clk);
    chk(got.size() == 2, "R4", "empty block length", got.size(), 2);
    if (got.size() == 2)
      chk(got[0] == 8'hFF && got[1] == 8'hFF, "R4", "empty block code",
          {got[0], got[1]}, 16'hFFFF);
  endtask

  task automatic rx_block(input logic [7:0] b[$], input bit crc, input bit clr_at_end);
    cfg_crc = crc;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    foreach (b[k]) begin
      rx_valid = 1'b1; rx_data = b[k];
      if (k == b.size() - 1) begin rx_end = 1'b1; err_clr = clr_at_end; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b0; err_clr = 1'b0;
  endtask

  task automatic test_rx();
    logic [7:0] b[$] = '{8'h00, 8'h40, 8'h03, 8'hAA};
    logic [7:0] f[$];
    logic [15:0] c;
    f = b; f.push_back(ref_lrc(b));
    rx_block(f, 1'b0, 1'b0);
    chk(rx_done && rx_ok, "R6", "LRC good block", {rx_done, rx_ok}, 3);
    chk(!err_flag, "R7", "no error on pass", err_flag, 0);
    @(negedge clk);
    chk(!rx_done, "R6", "done is one cycle", rx_done, 0);
    f[f.size() - 1] = f[f.size() - 1] ^ 8'h08;
    rx_block(f, 1'b0, 1'b0);
    chk(rx_done && !rx_ok, "R6", "LRC bad block", {rx_done, rx_ok}, 2);
    chk(err_flag, "R7", "error set with done", err_flag, 1);
    c = ref_crc(b);
    f = b; f.push_back(c[15:8]); f.push_back(c[7:0]);
    rx_block(f, 1'b1, 1'b0);
    chk(rx_done && rx_ok, "R6", "CRC good block", {rx_done, rx_ok}, 3);
    chk(err_flag, "R7", "error survives good block", err_flag, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(!err_flag, "R7", "error cleared", err_flag, 0);
    f[1] = f[1] ^ 8'h01;
    rx_block(f, 1'b1, 1'b1);
    chk(rx_done && !rx_ok, "R6", "CRC bad block", {rx_done, rx_ok}, 2);
    chk(err_flag, "R7", "set wins over clear", err_flag, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic test_disabled();
    logic [7:0] b[$] = '{8'h11, 8'h22, 8'h33};
    got.delete();
    cfg_en = 1'b0;
    cfg_crc = 1'b1;
    bp = 1;
    pulse_tx_start();
    foreach (b[k]) send_byte(b[k], 1'b0);
    pulse_tx_end();
    chk(!tx_busy, "R8", "no insertion when off", tx_busy, 0);
    repeat (8) @(negedge clk);
    chk(got.size() == 3, "R8", "pass-through length", got.size(), 3);
    foreach (b[k]) if (k < got.size())
      chk(got[k] == b[k], "R8", $sformatf("pass byte %0d", k), got[k], b[k]);
    rx_block('{8'h12, 8'h34}, 1'b1, 1'b0);
    chk(!rx_done, "R8", "no result when off", rx_done, 0);
    chk(!err_flag, "R8", "no error when off", err_flag, 0);
    cfg_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_lrc_tx();
    test_crc_tx();
    test_coincident_end();
    test_insert_stall();
    test_rx();
    test_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule